// File: doc/BRIEF.md
# First-Error Logging Machine-Check Controller

This block gathers error events from several bus-side sources and keeps a sticky detection bit for each one. Only the earliest error since the log was last empty has its details recorded: the faulting address, a bus status word, a flag telling whether the failing cycle came from the processor or from PCI, and a flag marking the address as unusable. Later errors still set their own detection bits but leave the recorded details alone. Software reads the detection bits and the recorded details, then empties the log by writing ones to the detection bits it wants cleared.

The block also drives a machine-check request to the processor core. The request rises when an enabled error is seen while the log is empty. It falls when the core issues a read whose low 20 address bits equal 0x00200, the machine-check vector, whatever the upper bits are. After that it stays low for every later error until all detection bits have been cleared. A sideband non-maskable error input, a PCI parity-error (PERR) input that can be ignored under a response control bit, and an internal parity-detect strobe feed dedicated detection bits. All error inputs are single-cycle pulses. All outputs are registered and change one clock after the input that causes them.

Top module: `mchk_err_logger`

## Requirements
- R1: Detection vector `det_o` has NUM_SRC+3 bits: bit i (i below NUM_SRC) belongs to `src_err_i[i]`, bit NUM_SRC to the sideband input, bit NUM_SRC+1 to PERR, bit NUM_SRC+2 to the parity-detect strobe. Each bit is set by its event and stays set, and events arriving in the same cycle set all their bits together.
- R2: On the first error seen while `det_o` is all zero, `log_addr_o`, `log_stat_o`, `log_pci_o` and `log_addr_bad_o` take the capture inputs of that cycle. They then hold, including after the log is cleared, until the next first error.
- R3: An error arriving while any detection bit is set sets its own bit and does not change the logged details.
- R4: `mchk_o` rises one cycle after an enabled error that arrives while `det_o` is all zero. A source i is enabled when `src_en_i[i]` is 1, and PERR is enabled when it is accepted.
- R5: Once high, `mchk_o` stays high until a cycle with `rd_valid_i` high and `rd_addr_i[19:0]` equal to 0x00200. The upper address bits are not compared. A read of any other address leaves it high.
- R6: After the vector read drops `mchk_o`, no error raises it again while any detection bit remains set.
- R7: The sideband input always sets its detection bit. It raises `mchk_o` only when `side_mc_en_i` is 1.
- R8: `perr_i` is ignored when `perr_resp_en_i` is 0, so no bit is set and there is no machine check. When it is 1, PERR sets bit NUM_SRC+1.
- R9: The parity-detect strobe sets bit NUM_SRC+2 but never raises `mchk_o`.
- R10: A source whose enable is 0 still sets its detection bit and still captures details as the first error, but does not raise `mchk_o`.
- R11: When `clr_we_i` is high, every detection bit with a 1 in `clr_mask_i` is cleared. An event for the same bit in the same cycle wins, and that bit stays set.
- R12: Reset leaves `det_o`, all logged details and `mchk_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_err_i | input | NUM_SRC | Per-source error pulses |
| src_en_i | input | NUM_SRC | Per-source machine-check enables |
| side_err_i | input | 1 | Sideband non-maskable error pulse |
| side_mc_en_i | input | 1 | Machine-check enable for the sideband error |
| perr_i | input | 1 | PCI parity-error (PERR) event pulse |
| perr_resp_en_i | input | 1 | Accept PERR events when high |
| par_det_i | input | 1 | Parity-error-detected strobe (status only) |
| cap_addr_i | input | 32 | Address to log for an error in this cycle |
| cap_stat_i | input | 8 | Bus status word to log |
| cap_pci_i | input | 1 | Cycle source flag to log (1 = PCI, 0 = processor) |
| cap_addr_bad_i | input | 1 | Marks the logged address as not meaningful |
| rd_valid_i | input | 1 | Processor read strobe |
| rd_addr_i | input | 32 | Processor read address |
| clr_we_i | input | 1 | Clear write strobe |
| clr_mask_i | input | NUM_SRC+3 | Write-one-to-clear mask for the detection bits |
| det_o | output | NUM_SRC+3 | Sticky detection bits |
| log_addr_o | output | 32 | Logged error address |
| log_stat_o | output | 8 | Logged bus status |
| log_pci_o | output | 1 | Logged cycle source flag |
| log_addr_bad_o | output | 1 | Logged invalid-address flag |
| mchk_o | output | 1 | Machine-check request to the core |

## Verification
Every result, whether a detection bit, the logged details or the machine-check level, sits behind exactly one register. It is therefore due at the clock edge that ends the cycle in which the pulse, read or clear write is presented. The bench drives each stimulus on a falling edge for one full cycle, removes it on the next falling edge, and samples at that falling edge, which lies half a period after the capturing rising edge. Capture inputs carry a distinct noise pattern outside error cycles, so a wrongly timed capture shows up as a wrong value.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
    localparam int LOG_ADDR_W = 32;
    localparam int LOG_STAT_W = 8;
    // machine-check vector: only the low bits of the read address are compared
    localparam int VEC_CMP_W = 20;
    localparam logic [VEC_CMP_W-1:0] VEC_OFFSET = 20'h00200;
    // detection bits above the per-source ones
    localparam int EXTRA_BITS = 3;

    typedef struct packed {
        logic [LOG_ADDR_W-1:0] addr;
        logic [LOG_STAT_W-1:0] stat;
        logic                  pci;
        logic                  addr_bad;
    } log_t;
endpackage

// File: rtl/mchk_vec_match.sv
module mchk_vec_match
    import mchk_pkg::*;
(
    input  logic                  rd_valid_i,
    input  logic [LOG_ADDR_W-1:0] rd_addr_i,
    output logic                  hit_o
);
    always_comb begin
        hit_o = rd_valid_i && (rd_addr_i[VEC_CMP_W-1:0] == VEC_OFFSET);
    end
endmodule

// File: rtl/mchk_src_qualify.sv
module mchk_src_qualify
    import mchk_pkg::*;
#(
    parameter int NUM_SRC = 4,
    localparam int DET_W  = NUM_SRC + EXTRA_BITS
) (
    input  logic [NUM_SRC-1:0] src_err_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               side_err_i,
    input  logic               side_mc_en_i,
    input  logic               perr_i,
    input  logic               perr_resp_en_i,
    input  logic               par_det_i,
    output logic [DET_W-1:0]   set_o,
    output logic               mc_req_o
);
    logic [NUM_SRC-1:0] src_req;
    logic               perr_ok;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign set_o[g]   = src_err_i[g];
        assign src_req[g] = src_err_i[g] & src_en_i[g];
    end

    always_comb begin
        perr_ok              = perr_i & perr_resp_en_i;
        set_o[NUM_SRC]       = side_err_i;
        set_o[NUM_SRC+1]     = perr_ok;
        set_o[NUM_SRC+2]     = par_det_i;
        mc_req_o             = (|src_req) | (side_err_i & side_mc_en_i) | perr_ok;
    end
endmodule

// File: rtl/mchk_err_logger.sv
module mchk_err_logger
    import mchk_pkg::*;
#(
    parameter int NUM_SRC = 4,
    localparam int DET_W  = NUM_SRC + EXTRA_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_err_i,
    input  logic [NUM_SRC-1:0]    src_en_i,
    input  logic                  side_err_i,
    input  logic                  side_mc_en_i,
    input  logic                  perr_i,
    input  logic                  perr_resp_en_i,
    input  logic                  par_det_i,
    input  logic [LOG_ADDR_W-1:0] cap_addr_i,
    input  logic [LOG_STAT_W-1:0] cap_stat_i,
    input  logic                  cap_pci_i,
    input  logic                  cap_addr_bad_i,
    input  logic                  rd_valid_i,
    input  logic [LOG_ADDR_W-1:0] rd_addr_i,
    input  logic                  clr_we_i,
    input  logic [DET_W-1:0]      clr_mask_i,
    output logic [DET_W-1:0]      det_o,
    output logic [LOG_ADDR_W-1:0] log_addr_o,
    output logic [LOG_STAT_W-1:0] log_stat_o,
    output logic                  log_pci_o,
    output logic                  log_addr_bad_o,
    output logic                  mchk_o
);
    typedef struct packed {
        logic [DET_W-1:0] det;
        log_t             log;
        logic             mc;
    } state_t;

    state_t st_d, st_q;

    logic [DET_W-1:0] set_vec;
    logic             mc_req;
    logic             vec_hit;
    logic             log_open;
    logic [DET_W-1:0] clr_vec;

    mchk_src_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
        .src_err_i      (src_err_i),
        .src_en_i       (src_en_i),
        .side_err_i     (side_err_i),
        .side_mc_en_i   (side_mc_en_i),
        .perr_i         (perr_i),
        .perr_resp_en_i (perr_resp_en_i),
        .par_det_i      (par_det_i),
        .set_o          (set_vec),
        .mc_req_o       (mc_req)
    );

    mchk_vec_match u_vec (
        .rd_valid_i (rd_valid_i),
        .rd_addr_i  (rd_addr_i),
        .hit_o      (vec_hit)
    );

    always_comb begin
        st_d     = st_q;
        log_open = (st_q.det == '0);
        clr_vec  = clr_we_i ? clr_mask_i : '0;
        // new events override a clear of the same bit
        st_d.det = (st_q.det & ~clr_vec) | set_vec;
        if (log_open && (set_vec != '0)) begin
            st_d.log.addr     = cap_addr_i;
            st_d.log.stat     = cap_stat_i;
            st_d.log.pci      = cap_pci_i;
            st_d.log.addr_bad = cap_addr_bad_i;
        end
        if (vec_hit) begin
            st_d.mc = 1'b0;
        end
        if (log_open && mc_req) begin
            st_d.mc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_o          = st_q.det;
    assign log_addr_o     = st_q.log.addr;
    assign log_stat_o     = st_q.log.stat;
    assign log_pci_o      = st_q.log.pci;
    assign log_addr_bad_o = st_q.log.addr_bad;
    assign mchk_o         = st_q.mc;

    AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((det_o & $past(det_o)) == $past(det_o))) else $error("sticky"); // R1
    AST_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (det_o != '0) |=> $stable(log_addr_o) && $stable(log_stat_o)) else $error("log"); // R3
    AST_MC_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mchk_o) |-> ($past(det_o) == '0)) else $error("rise"); // R6
    AST_MC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_o && !vec_hit) |=> mchk_o) else $error("hold"); // R5
    AST_MC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_o && vec_hit && (det_o != '0)) |=> !mchk_o) else $error("drop"); // R5
endmodule

// File: tb/mchk_err_logger_bench.sv
module mchk_err_logger_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int DW = NS + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] src_err_i = '0, src_en_i = '0;
    logic side_err_i = 0, side_mc_en_i = 0, perr_i = 0, perr_resp_en_i = 0, par_det_i = 0;
    logic [31:0] cap_addr_i = 32'hDEAD_0000;
    logic [7:0]  cap_stat_i = 8'hEE;
    logic cap_pci_i = 0, cap_addr_bad_i = 0, rd_valid_i = 0, clr_we_i = 0;
    logic [31:0] rd_addr_i = '0;
    logic [DW-1:0] clr_mask_i = '0;
    logic [DW-1:0] det_o;
    logic [31:0] log_addr_o;
    logic [7:0]  log_stat_o;
    logic log_pci_o, log_addr_bad_o, mchk_o;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mchk_err_logger #(.NUM_SRC(NS)) u_mchk_err_logger (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // one-cycle error pulse with capture values; results sampled next negedge
    task automatic err_pulse(input logic [NS-1:0] src, input logic side, input logic perr,
                             input logic pdet, input logic [31:0] a, input logic [7:0] s,
                             input logic pci, input logic bad);
        @(negedge clk);
        src_err_i = src; side_err_i = side; perr_i = perr; par_det_i = pdet;
        cap_addr_i = a; cap_stat_i = s; cap_pci_i = pci; cap_addr_bad_i = bad;
        @(negedge clk);
        src_err_i = '0; side_err_i = 0; perr_i = 0; par_det_i = 0;
        cap_addr_i = 32'hDEAD_0000 ^ a; cap_stat_i = ~s; cap_pci_i = ~pci; cap_addr_bad_i = ~bad;
    endtask

    task automatic cpu_read(input logic [31:0] a);
        @(negedge clk); rd_valid_i = 1; rd_addr_i = a;
        @(negedge clk); rd_valid_i = 0;
    endtask

    task automatic clear(input logic [DW-1:0] m);
        @(negedge clk); clr_we_i = 1; clr_mask_i = m;
        @(negedge clk); clr_we_i = 0; clr_mask_i = '0;
    endtask

    task automatic t_reset;
        chk_eq("R12 det", det_o, 0);
        chk_eq("R12 addr", log_addr_o, 0);
        chk_eq("R12 stat/flags", {log_stat_o, log_pci_o, log_addr_bad_o}, 0);
        chk_eq("R12 mchk", mchk_o, 0);
    endtask

    task automatic t_first_and_later;
        src_en_i = '1;
        err_pulse(4'b0100, 0, 0, 0, 32'h1234_5678, 8'h5A, 1, 0);
        chk_eq("R1 bit2", det_o, 7'b000_0100);
        chk_eq("R2 addr", log_addr_o, 32'h1234_5678);
        chk_eq("R2 stat", {log_stat_o, log_pci_o, log_addr_bad_o}, {8'h5A, 1'b1, 1'b0});
        chk_eq("R4 mchk", mchk_o, 1);
        err_pulse(4'b0001, 0, 0, 0, 32'hAAAA_BBBB, 8'h11, 0, 1);
        chk_eq("R3 det", det_o, 7'b000_0101);
        chk_eq("R3 addr held", log_addr_o, 32'h1234_5678);
        chk_eq("R3 stat held", {log_stat_o, log_pci_o, log_addr_bad_o}, {8'h5A, 1'b1, 1'b0});
    endtask

    task automatic t_vector;
        cpu_read(32'h0000_0300);
        chk_eq("R5 other read", mchk_o, 1);
        cpu_read(32'hFFF0_0200);
        chk_eq("R5 vector hit upper ignored", mchk_o, 0);
        err_pulse(4'b0010, 0, 0, 0, 32'h0, 8'h0, 0, 0);
        chk_eq("R6 no reassert", mchk_o, 0);
        chk_eq("R6 bit1 set", det_o, 7'b000_0111);
        clear(7'b000_0100);
        chk_eq("R11 partial clear", det_o, 7'b000_0011);
        err_pulse(4'b1000, 0, 0, 0, 32'h0, 8'h0, 0, 0);
        chk_eq("R6 still blocked", mchk_o, 0);
        clear('1);
        chk_eq("R11 full clear", det_o, 0);
        chk_eq("R2 held after clear", log_addr_o, 32'h1234_5678);
    endtask

    task automatic t_disabled;
        src_en_i = 4'b1101;
        err_pulse(4'b0010, 0, 0, 0, 32'hCAFE_F00D, 8'h77, 0, 1);
        chk_eq("R10 bit set", det_o, 7'b000_0010);
        chk_eq("R10 no mchk", mchk_o, 0);
        chk_eq("R10 captured", {log_addr_o, log_addr_bad_o}, {32'hCAFE_F00D, 1'b1});
        clear('1);
        src_en_i = '1;
    endtask

    task automatic t_side;
        side_mc_en_i = 0;
        err_pulse('0, 1, 0, 0, 32'h1, 8'h1, 0, 0);
        chk_eq("R7 bit", det_o, 7'b001_0000);
        chk_eq("R7 gated", mchk_o, 0);
        clear('1);
        side_mc_en_i = 1;
        err_pulse('0, 1, 0, 0, 32'h2, 8'h2, 0, 0);
        chk_eq("R7 enabled", mchk_o, 1);
        cpu_read(32'h0000_0200);
        clear('1);
        chk_eq("R7 after cleanup", {det_o, mchk_o}, 0);
    endtask

    task automatic t_parity;
        perr_resp_en_i = 0;
        err_pulse('0, 0, 1, 0, 32'h3, 8'h3, 0, 0);
        chk_eq("R8 ignored det", det_o, 0);
        chk_eq("R8 ignored mchk", mchk_o, 0);
        chk_eq("R8 ignored log", log_addr_o, 32'h2);
        perr_resp_en_i = 1;
        err_pulse('0, 0, 1, 0, 32'h4, 8'h4, 0, 0);
        chk_eq("R8 accepted", {det_o, mchk_o}, {7'b010_0000, 1'b1});
        cpu_read(32'h0000_0200);
        clear('1);
        err_pulse('0, 0, 0, 1, 32'h5, 8'h5, 0, 0);
        chk_eq("R9 bit", det_o, 7'b100_0000);
        chk_eq("R9 no mchk", mchk_o, 0);
        clear('1);
    endtask

    task automatic t_simul_and_race;
        err_pulse(4'b1001, 0, 0, 0, 32'h6, 8'h6, 0, 0);
        chk_eq("R1 simultaneous", det_o, 7'b000_1001);
        cpu_read(32'h0000_0200);
        @(negedge clk);
        clr_we_i = 1; clr_mask_i = '1; src_err_i = 4'b1000;
        @(negedge clk);
        clr_we_i = 0; clr_mask_i = '0; src_err_i = '0;
        chk_eq("R11 set wins", det_o, 7'b000_1000);
        clear('1);
        chk_eq("R11 cleared", det_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_first_and_later;
        t_vector;
        t_disabled;
        t_side;
        t_parity;
        t_simul_and_race;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule